// File: doc/BRIEF.md
# PCI Interrupt Line to Legacy Controller Router

This block steers four level-sensitive PCI interrupt request lines onto the sixteen inputs of a legacy programmable interrupt controller. Software picks a destination for each request line by writing one routing byte per line through a small configuration port. A routing byte below 16 names the controller input that the line drives. A value of 16 or more detaches the line. When several request lines name the same input, that input goes high while any of them is high.

The router keeps an internal 64-bit level map. Bit `input*4 + line` holds the line's level while the line is routed to that input. The map is rebuilt from scratch on every clock from the live request levels and the routing bytes, so every output is re-evaluated after each routing write. The controller outputs are read straight from the registered map and change one clock after a level change or a routing write.

A separate combinational helper works out which request line a device pin reaches. The device's slot is its device/function number shifted right by three. The pin number is 0 for INTA up to 3 for INTD. The line index is (pin + slot − 1) modulo 4.

Top module: `pirq_router`

## Requirements
- R1: After reset all four routing bytes read 0x80, every request line is detached and all sixteen controller outputs are low.
- R2: `slot_pirq` equals (`slot_pin` + (`slot_devfn` >> 3) − 1) modulo 4, where pin codes 0..3 stand for INTA..INTD. The result is combinational.
- R3: The routing bytes live in the dword whose byte address is 0x60. Byte lane 0 (bits 7:0, address 0x60) routes line A, lane 1 routes B, lane 2 routes C and lane 3 routes D. A write whose `cfg_addr[7:2]` differs from 0x18 changes no routing byte.
- R4: Each controller output equals the OR of the levels of all request lines whose routing byte holds that output's index. The output shows this one clock after a level change.
- R5: A routing byte of 16 or more makes its request line drive no controller output.
- R6: Request lines that share a controller input are ORed. The input stays high until every sharing line is low.
- R7: A read of dword 0x60 returns the four routing bytes last written, with line A in bits 7:0. Any other dword reads as zero.
- R8: After a routing write, every controller output reflects the new routing one clock after the write edge. This includes the output a line has just left.
- R9: Only byte lanes whose `cfg_be` bit is set are written. The other routing bytes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address (dword selected by bits 7:2) |
| cfg_be | input | 4 | Byte enables, one per lane |
| cfg_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| cfg_rdata | output | 32 | Read data for the dword at `cfg_addr` |
| pirq_lvl | input | 4 | Request line levels, bit 0 = line A |
| pic_lvl | output | 16 | Controller input levels, bit k = input k |
| slot_devfn | input | 8 | Device/function number for the pin helper |
| slot_pin | input | 2 | Interrupt pin code of the device, 0 = INTA |
| slot_pirq | output | 2 | Request line index the pin reaches |

## Verification
The bench aims at the boundary routing values 15 and 16. A design that compared with the wrong limit would either lose input 15 or drive a phantom input from a detached line. It routes two lines onto one input and drops them one at a time; an arbiter that let the last writer win would let that input fall too early. It moves an asserted line to a new input and checks that the old input falls in the same cycle as the new one rises; a design that only patched the new entry would leave the old one stuck high. It also sends writes to neighbouring dwords and with partial byte enables, which catches decoders that ignore the address or the lanes. A sweep over every slot and pin checks the wrap of the slot helper at slot 0.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int PIRQ_N     = 4;
    localparam int PIC_N      = 16;
    localparam int ROUTE_W    = 8;
    localparam int MAP_W      = PIRQ_N * PIC_N;
    localparam logic [7:0] ROUTE_BASE = 8'h60;
    localparam logic [7:0] ROUTE_RESET = 8'h80;
endpackage

// File: rtl/pirq_slot_map.sv
module pirq_slot_map #(
    parameter int N_PIRQ = pirq_pkg::PIRQ_N,
    localparam int IDX_W = $clog2(N_PIRQ)
) (
    input  logic [7:0]       devfn,
    input  logic [IDX_W-1:0] pin,
    output logic [IDX_W-1:0] pirq
);
    logic [4:0]       slot;
    logic [IDX_W-1:0] slot_lo;

    always_comb begin
        slot    = devfn[7:3];
        slot_lo = slot[IDX_W-1:0];
        // modulo wrap comes from the narrow result width
        pirq    = pin + slot_lo - IDX_W'(1);
    end

    always_comb begin
        if (devfn[7:3] == 5'd1) begin
            AST_SLOT1_IDENTITY: assert (pirq == pin); // R2
        end
    end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs #(
    parameter int         N_PIRQ = pirq_pkg::PIRQ_N,
    parameter logic [7:0] BASE   = pirq_pkg::ROUTE_BASE,
    localparam int        RW     = pirq_pkg::ROUTE_W,
    localparam int        DW     = N_PIRQ * RW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [7:0]        addr,
    input  logic [N_PIRQ-1:0] be,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     route_q_o,
    output logic [DW-1:0]     route_d_o,
    output logic [DW-1:0]     rdata
);
    typedef struct packed {
        logic [DW-1:0] route;
    } regs_t;

    regs_t st_d, st_q;
    logic  hit;

    always_comb begin
        hit  = (addr[7:2] == BASE[7:2]);
        st_d = st_q;
        if (wr && hit) begin
            for (int i = 0; i < N_PIRQ; i++) begin
                if (be[i]) st_d.route[i*RW +: RW] = wdata[i*RW +: RW];
            end
        end
        rdata = hit ? st_q.route : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.route <= {N_PIRQ{pirq_pkg::ROUTE_RESET}};
        else        st_q       <= st_d;
    end

    assign route_q_o = st_q.route;
    assign route_d_o = st_d.route;

    AST_MISS_KEEPS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && hit) |=> $stable(route_q_o)); // R3

    generate
        for (genvar g = 0; g < N_PIRQ; g++) begin : g_lane
            AST_LANE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
                !be[g] |=> $stable(route_q_o[g*RW +: RW])); // R9
        end
    endgenerate
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map #(
    parameter int  N_PIRQ = pirq_pkg::PIRQ_N,
    parameter int  N_PIC  = pirq_pkg::PIC_N,
    localparam int RW     = pirq_pkg::ROUTE_W,
    localparam int MW     = N_PIRQ * N_PIC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_PIRQ*RW-1:0] route_next,
    input  logic [N_PIRQ-1:0]    pirq_lvl,
    output logic [N_PIC-1:0]     pic_lvl
);
    typedef struct packed {
        logic [MW-1:0] map;
    } map_st_t;

    map_st_t st_d, st_q;

    always_comb begin
        st_d.map = '0;
        for (int p = 0; p < N_PIRQ; p++) begin
            for (int k = 0; k < N_PIC; k++) begin
                if (pirq_lvl[p] && (32'(route_next[p*RW +: RW]) == k))
                    st_d.map[k*N_PIRQ + p] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.map <= '0;
        else        st_q     <= st_d;
    end

    generate
        for (genvar k = 0; k < N_PIC; k++) begin : g_pic
            assign pic_lvl[k] = |st_q.map[k*N_PIRQ +: N_PIRQ];
        end
    endgenerate

    logic [N_PIC-1:0] col [N_PIRQ];
    always_comb begin
        for (int p = 0; p < N_PIRQ; p++)
            for (int k = 0; k < N_PIC; k++)
                col[p][k] = st_q.map[k*N_PIRQ + p];
    end

    generate
        for (genvar p = 0; p < N_PIRQ; p++) begin : g_col
            AST_LINE_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(col[p])); // R4
            AST_DETACHED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
                (route_next[p*RW +: RW] >= RW'(N_PIC)) |=> (col[p] == '0)); // R5
        end
    endgenerate
endmodule

// File: rtl/pirq_router.sv
module pirq_router #(
    parameter int  N_PIRQ = pirq_pkg::PIRQ_N,
    parameter int  N_PIC  = pirq_pkg::PIC_N,
    localparam int RW     = pirq_pkg::ROUTE_W,
    localparam int IDX_W  = $clog2(N_PIRQ)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [7:0]           cfg_addr,
    input  logic [N_PIRQ-1:0]    cfg_be,
    input  logic [N_PIRQ*RW-1:0] cfg_wdata,
    output logic [N_PIRQ*RW-1:0] cfg_rdata,
    input  logic [N_PIRQ-1:0]    pirq_lvl,
    output logic [N_PIC-1:0]     pic_lvl,
    input  logic [7:0]           slot_devfn,
    input  logic [IDX_W-1:0]     slot_pin,
    output logic [IDX_W-1:0]     slot_pirq
);
    logic [N_PIRQ*RW-1:0] route_q;
    logic [N_PIRQ*RW-1:0] route_d;

    pirq_route_regs #(.N_PIRQ(N_PIRQ)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .addr      (cfg_addr),
        .be        (cfg_be),
        .wdata     (cfg_wdata),
        .route_q_o (route_q),
        .route_d_o (route_d),
        .rdata     (cfg_rdata)
    );

    pirq_level_map #(.N_PIRQ(N_PIRQ), .N_PIC(N_PIC)) i_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .route_next (route_d),
        .pirq_lvl   (pirq_lvl),
        .pic_lvl    (pic_lvl)
    );

    pirq_slot_map #(.N_PIRQ(N_PIRQ)) i_slot (
        .devfn (slot_devfn),
        .pin   (slot_pin),
        .pirq  (slot_pirq)
    );

    AST_QUIET_LINES_QUIET_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pirq_lvl == '0) |=> (pic_lvl == '0)); // R4
    AST_OUTPUT_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pic_lvl) <= N_PIRQ)); // R6
endmodule

// File: tb/test_pirq_router.sv
`timescale 1ns/1ps
module test_pirq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic [3:0]  pirq_lvl = 4'h0;
    logic [15:0] pic_lvl;
    logic [7:0]  slot_devfn = 8'h0;
    logic [1:0]  slot_pin = 2'd0;
    logic [1:0]  slot_pirq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [31:0] m_route;
    logic [15:0] exp_pic;

    always #4 clk = ~clk;

    pirq_router i_pirq_router (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pirq_lvl(pirq_lvl), .pic_lvl(pic_lvl), .slot_devfn(slot_devfn),
        .slot_pin(slot_pin), .slot_pirq(slot_pirq)
    );

    function automatic logic [15:0] f_pic(input logic [31:0] r, input logic [3:0] l);
        logic [15:0] o = '0;
        for (int p = 0; p < 4; p++)
            if (l[p] && r[p*8 +: 8] < 8'd16) o[r[p*8 +: 4]] = 1'b1;
        return o;
    endfunction

    function automatic logic [1:0] f_slot(input logic [7:0] df, input logic [1:0] pin);
        int v = (int'(pin) + int'(df >> 3) - 1 + 4) % 4;
        return 2'(v);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // check the previous cycle's effect, then drive the next stimulus
    task automatic step(input string req, input logic wr, input logic [7:0] a,
                        input logic [3:0] be, input logic [31:0] wd, input logic [3:0] lvl);
        @(negedge clk);
        chk(req, 32'(pic_lvl), 32'(exp_pic));
        chk("R7", cfg_rdata, (cfg_addr[7:2] == 6'h18) ? m_route : 32'h0);
        cfg_wr = wr; cfg_addr = a; cfg_be = be; cfg_wdata = wd; pirq_lvl = lvl;
        if (wr && a[7:2] == 6'h18)
            for (int i = 0; i < 4; i++) if (be[i]) m_route[i*8 +: 8] = wd[i*8 +: 8];
        exp_pic = f_pic(m_route, lvl);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_route = 32'h80808080;
        exp_pic = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cfg_addr = 8'h60;
        pirq_lvl = 4'hF;
        exp_pic = 16'h0;
        @(negedge clk);
        chk("R1", cfg_rdata, 32'h80808080);
        chk("R1", 32'(pic_lvl), 32'h0);

        // R2 sweep over every slot and pin
        for (int s = 0; s < 32; s++) begin
            for (int p = 0; p < 4; p++) begin
                slot_devfn = 8'(s << 3) | 8'(s % 8);
                slot_pin = 2'(p);
                #1;
                chk("R2", 32'(slot_pirq), 32'(f_slot(slot_devfn, slot_pin)));
            end
        end

        // R6 sharing: A and C on 5, B detached at 16, D on boundary 15
        step("R4", 1'b1, 8'h60, 4'hF, 32'h0F_05_10_05, 4'hF);
        step("R6", 1'b0, 8'h60, 4'h0, 32'h0, 4'b1110);
        step("R6", 1'b0, 8'h60, 4'h0, 32'h0, 4'b1010);
        step("R5", 1'b0, 8'h60, 4'h0, 32'h0, 4'b0010);
        // R8 move asserted line A from 5 to 7
        step("R6", 1'b0, 8'h60, 4'h0, 32'h0, 4'b0001);
        step("R8", 1'b1, 8'h62, 4'h1, 32'h0000_0007, 4'b0001);
        // R9 partial lanes: only lane 2 (line C)
        step("R8", 1'b1, 8'h60, 4'h4, 32'hFF_03_FF_FF, 4'b0101);
        // R3 neighbouring dwords are ignored
        step("R9", 1'b1, 8'h64, 4'hF, 32'h00000000, 4'b1111);
        step("R3", 1'b1, 8'h5C, 4'hF, 32'h01010101, 4'b1111);
        step("R3", 1'b0, 8'h60, 4'h0, 32'h0, 4'b1111);
        step("R3", 1'b0, 8'h60, 4'h0, 32'h0, 4'b0000);

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] wd;
            logic [7:0]  a;
            for (int i = 0; i < 4; i++) begin
                int c = $urandom % 22;
                wd[i*8 +: 8] = (c < 16) ? 8'(c) : ((c < 20) ? 8'(16 + $urandom % 240) : 8'h80);
            end
            a = ($urandom % 4 != 0) ? (8'h60 | 8'($urandom % 4)) : 8'($urandom);
            step("R4", ($urandom % 3) == 0, a, 4'($urandom), wd, 4'($urandom));
        end
        step("R4", 1'b0, 8'h60, 4'h0, 32'h0, 4'h0);
        step("R4", 1'b0, 8'h60, 4'h0, 32'h0, 4'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule